// File: doc/BRIEF.md
# Translation Fault Classifier

This block sits at the end of an address translation path. It takes one memory access, a 64-bit effective address plus its kind (load, store or instruction fetch), together with what earlier stages already found out: whether a segment entry matched, whether that segment forbids execution, whether a page-table entry matched, and that entry's permissions, changed bit and real page number. From these it returns one verdict. The verdict is either a real address with the permissions to install, or a fault with its exception class, error code, fault-address value and data status word.

The checks are applied in a fixed priority. The first one that fails sets the outcome. Instruction-side and data-side faults are reported differently: only data faults load the fault-address register, and only data storage faults load the status word. Two plain control inputs select real mode, one for the instruction side and one for the data side.

Requests and responses use valid/ready handshakes with one register stage between them. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle. While a response waits for `rsp_ready`, it stays unchanged and no new request is taken.

Top module: `xlat_fault_classifier`

## Requirements
- R1: A fetch with `instr_reloc_on` low, or a load or store with `data_reloc_on` low, bypasses every other check. The response has no fault, a real address equal to the effective address with bits 63:60 cleared, and `rsp_perm` = 3'b111. The relocation input for the other side has no effect on the outcome.
- R2: The checks run in this priority: bypass, segment miss, segment no-execute (fetch only), page-table miss, permission violation. Only the first failing check is reported.
- R3: A segment miss (`seg_hit` low) on a fetch gives `rsp_exc` = 1 with error code 0 and no register writes. On a load or store it gives `rsp_exc` = 2 with error code 0, `far_we` high, `far_val` equal to the effective address and `dsisr_we` low.
- R4: A fetch from a segment with `seg_no_exec` high gives `rsp_exc` = 3 with error code 32'h1000_0000. For loads and stores `seg_no_exec` is ignored.
- R5: A page-table miss (`pte_hit` low) on a fetch gives `rsp_exc` = 3 with error code 32'h4000_0000. On a load or store it gives `rsp_exc` = 4 with error code 0, the fault address loaded, and the status word 32'h4200_0000 for a store or 32'h4000_0000 for a load.
- R6: A permission violation on a fetch gives `rsp_exc` = 3 with error code 32'h0800_0000. On a load or store it gives `rsp_exc` = 4 with error code 0, the fault address loaded, and the status word 32'h0A00_0000 for a store or 32'h0800_0000 for a load.
- R7: `req_acc` encodes 0 = load, 1 = store, 2 = fetch, and 3 is treated as a load. The access needs permission bit 0 (read) for a load, bit 1 (write) for a store and bit 2 (execute) for a fetch, in both `pte_perm` and `rsp_perm`. The access faults when the needed bit is clear in `pte_perm`.
- R8: On a translated success where the access is not a store and `pte_changed` is low, `rsp_perm` is `pte_perm` with bit 1 cleared. Otherwise `rsp_perm` equals `pte_perm`.
- R9: On a translated success, `rsp_raddr` = {`pte_rpn`, effective address bits [PAGE_BITS-1:0]}.
- R10: After reset `rsp_valid` is low and `req_ready` is high. An accepted request shows up as `rsp_valid` on the next clock. While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold and `req_ready` is low.
- R11: A success response has `rsp_exc` = 0, error code 0, `far_we` and `dsisr_we` low. A fault response has `rsp_fault` high, `rsp_raddr` = 0 and `rsp_perm` = 0. Instruction-side faults never raise `far_we` or `dsisr_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ea | input | 64 | Effective address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| instr_reloc_on | input | 1 | Instruction-side translation enabled |
| data_reloc_on | input | 1 | Data-side translation enabled |
| seg_hit | input | 1 | Segment lookup matched |
| seg_no_exec | input | 1 | Matched segment forbids execution |
| pte_hit | input | 1 | Page-table entry found |
| pte_perm | input | 3 | Entry permissions: bit 0 read, bit 1 write, bit 2 execute |
| pte_changed | input | 1 | Entry changed bit |
| pte_rpn | input | 52 | Real page number |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Response is a fault |
| rsp_raddr | output | 64 | Real address on success, else 0 |
| rsp_perm | output | 3 | Granted permissions on success, else 0 |
| rsp_exc | output | 3 | 0 none, 1 instr segment, 2 data segment, 3 instr storage, 4 data storage |
| rsp_err_code | output | 32 | Exception error code |
| far_we | output | 1 | Load fault-address register |
| far_val | output | 64 | Fault-address value |
| dsisr_we | output | 1 | Load data status word |
| dsisr_val | output | 32 | Data status word value |

## Verification
All decisions are made in one cycle and registered once. A wrong priority, a swapped instruction/data selection or a wrong status constant therefore shows up in the very next response after the triggering request. There is no hidden state that could delay a symptom. The only state that lasts is the output register under back-pressure, and a fault there shows within one stalled cycle as a payload change or a lost or duplicated response. Each fault path is driven with the lower-priority failures also present, so a reordered chain is exposed on the first such request.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_ISEG  = 3'd1,
    EXC_DSEG  = 3'd2,
    EXC_ISTOR = 3'd3,
    EXC_DSTOR = 3'd4
  } exc_e;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  localparam logic [31:0] CODE_NOEXEC  = 32'h1000_0000;
  localparam logic [31:0] CODE_NOENTRY = 32'h4000_0000;
  localparam logic [31:0] CODE_DENIED  = 32'h0800_0000;
  localparam logic [31:0] STAT_STORE   = 32'h0200_0000;

  typedef struct packed {
    logic        fault;
    exc_e        exc;
    logic [31:0] err;
    logic        far_we;
    logic        dsisr_we;
    logic [31:0] dsisr;
    logic [2:0]  perm;
  } verdict_t;

endpackage

// File: rtl/xfc_perm_eval.sv
module xfc_perm_eval
  import xfc_pkg::*;
(
  input  logic [1:0] acc,
  input  logic [2:0] pte_perm,
  input  logic       pte_changed,
  output logic       violate,
  output logic [2:0] granted
);

  logic [2:0] need;
  logic       is_store;

  always_comb begin
    need = '0;
    unique case (acc)
      ACC_STORE: need[PERM_WR] = 1'b1;
      ACC_FETCH: need[PERM_EX] = 1'b1;
      default:   need[PERM_RD] = 1'b1;
    endcase
  end

  assign is_store = (acc == ACC_STORE);
  assign violate  = |(need & ~pte_perm);

  always_comb begin
    granted = pte_perm;
    if (!is_store && !pte_changed) granted[PERM_WR] = 1'b0;
  end

endmodule

// File: rtl/xfc_classify.sv
module xfc_classify
  import xfc_pkg::*;
(
  input  logic       is_fetch,
  input  logic       is_store,
  input  logic       bypass,
  input  logic       seg_hit,
  input  logic       seg_no_exec,
  input  logic       pte_hit,
  input  logic       violate,
  input  logic [2:0] granted,
  output verdict_t   verdict
);

  always_comb begin
    verdict      = '0;
    verdict.exc  = EXC_NONE;
    verdict.perm = granted;
    if (bypass) begin
      verdict.perm = 3'b111;
    end else if (!seg_hit) begin
      verdict.fault = 1'b1;
      verdict.perm  = '0;
      if (is_fetch) begin
        verdict.exc = EXC_ISEG;
      end else begin
        verdict.exc    = EXC_DSEG;
        verdict.far_we = 1'b1;
      end
    end else if (is_fetch && seg_no_exec) begin
      verdict.fault = 1'b1;
      verdict.perm  = '0;
      verdict.exc   = EXC_ISTOR;
      verdict.err   = CODE_NOEXEC;
    end else if (!pte_hit || violate) begin
      verdict.fault = 1'b1;
      verdict.perm  = '0;
      if (is_fetch) begin
        verdict.exc = EXC_ISTOR;
        verdict.err = pte_hit ? CODE_DENIED : CODE_NOENTRY;
      end else begin
        verdict.exc      = EXC_DSTOR;
        verdict.far_we   = 1'b1;
        verdict.dsisr_we = 1'b1;
        verdict.dsisr    = (pte_hit ? CODE_DENIED : CODE_NOENTRY)
                         | (is_store ? STAT_STORE : 32'h0);
      end
    end
  end

endmodule

// File: rtl/xfc_addr_form.sv
module xfc_addr_form #(
  parameter int EA_W       = 64,
  parameter int PAGE_BITS  = 12,
  parameter int REAL_DROP  = 4,
  localparam int RPN_W     = EA_W - PAGE_BITS
) (
  input  logic [EA_W-1:0]  ea,
  input  logic [RPN_W-1:0] rpn,
  input  logic             bypass,
  input  logic             fault,
  output logic [EA_W-1:0]  raddr
);

  logic [EA_W-1:0] real_mode_addr;
  logic [EA_W-1:0] paged_addr;

  generate
    if (REAL_DROP > 0) begin : g_drop
      assign real_mode_addr = {{REAL_DROP{1'b0}}, ea[EA_W-REAL_DROP-1:0]};
    end else begin : g_keep
      assign real_mode_addr = ea;
    end
  endgenerate

  assign paged_addr = {rpn, ea[PAGE_BITS-1:0]};

  always_comb begin
    if (fault)       raddr = '0;
    else if (bypass) raddr = real_mode_addr;
    else             raddr = paged_addr;
  end

endmodule

// File: rtl/xlat_fault_classifier.sv
module xlat_fault_classifier
  import xfc_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int PAGE_BITS = 12,
  parameter int REAL_DROP = 4,
  localparam int RPN_W    = EA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [EA_W-1:0]  req_ea,
  input  logic [1:0]       req_acc,
  input  logic             instr_reloc_on,
  input  logic             data_reloc_on,
  input  logic             seg_hit,
  input  logic             seg_no_exec,
  input  logic             pte_hit,
  input  logic [2:0]       pte_perm,
  input  logic             pte_changed,
  input  logic [RPN_W-1:0] pte_rpn,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [EA_W-1:0]  rsp_raddr,
  output logic [2:0]       rsp_perm,
  output logic [2:0]       rsp_exc,
  output logic [31:0]      rsp_err_code,
  output logic             far_we,
  output logic [EA_W-1:0]  far_val,
  output logic             dsisr_we,
  output logic [31:0]      dsisr_val
);

  logic            is_fetch, is_store, bypass, violate, take;
  logic [2:0]      granted;
  verdict_t        verdict, verdict_q;
  logic [EA_W-1:0] raddr_d, raddr_q, far_q;
  logic            valid_q;

  assign is_fetch = (req_acc == ACC_FETCH);
  assign is_store = (req_acc == ACC_STORE);
  assign bypass   = is_fetch ? !instr_reloc_on : !data_reloc_on;

  xfc_perm_eval u_perm (
    .acc        (req_acc),
    .pte_perm   (pte_perm),
    .pte_changed(pte_changed),
    .violate    (violate),
    .granted    (granted)
  );

  xfc_classify u_cls (
    .is_fetch   (is_fetch),
    .is_store   (is_store),
    .bypass     (bypass),
    .seg_hit    (seg_hit),
    .seg_no_exec(seg_no_exec),
    .pte_hit    (pte_hit),
    .violate    (violate),
    .granted    (granted),
    .verdict    (verdict)
  );

  xfc_addr_form #(
    .EA_W     (EA_W),
    .PAGE_BITS(PAGE_BITS),
    .REAL_DROP(REAL_DROP)
  ) u_addr (
    .ea    (req_ea),
    .rpn   (pte_rpn),
    .bypass(bypass),
    .fault (verdict.fault),
    .raddr (raddr_d)
  );

  assign req_ready = !valid_q || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
      raddr_q   <= '0;
      far_q     <= '0;
    end else begin
      if (take) begin
        valid_q   <= 1'b1;
        verdict_q <= verdict;
        raddr_q   <= raddr_d;
        far_q     <= verdict.far_we ? req_ea : '0;
      end else if (rsp_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_fault    = verdict_q.fault;
  assign rsp_raddr    = raddr_q;
  assign rsp_perm     = verdict_q.perm;
  assign rsp_exc      = verdict_q.exc;
  assign rsp_err_code = verdict_q.err;
  assign far_we       = verdict_q.far_we;
  assign far_val      = far_q;
  assign dsisr_we     = verdict_q.dsisr_we;
  assign dsisr_val    = verdict_q.dsisr;

endmodule

// File: rtl/xfc_checker.sv
module xfc_checker
  import xfc_pkg::*;
#(
  parameter int EA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_fault,
  input logic [EA_W-1:0] rsp_raddr,
  input logic [2:0]      rsp_perm,
  input logic [2:0]      rsp_exc,
  input logic [31:0]     rsp_err_code,
  input logic            far_we,
  input logic [EA_W-1:0] far_val,
  input logic            dsisr_we,
  input logic [31:0]     dsisr_val
);

  assert_accept_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_fault, rsp_raddr,
      rsp_perm, rsp_exc, rsp_err_code, far_we, far_val, dsisr_we, dsisr_val})));

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_success_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_exc == EXC_NONE && rsp_err_code == 32'h0
      && !far_we && !dsisr_we));

  assert_fault_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_exc != EXC_NONE && rsp_perm == 3'b000
      && rsp_raddr == '0));

  assert_far_data_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && far_we) |-> (rsp_exc == EXC_DSEG || rsp_exc == EXC_DSTOR));

  assert_status_dstor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && dsisr_we) |-> (rsp_exc == EXC_DSTOR && far_we));

  assert_seg_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_exc == EXC_ISEG || rsp_exc == EXC_DSEG))
      |-> (rsp_err_code == 32'h0 && !dsisr_we));

endmodule

bind xlat_fault_classifier xfc_checker #(.EA_W(EA_W)) u_xfc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_fault   (rsp_fault),
  .rsp_raddr   (rsp_raddr),
  .rsp_perm    (rsp_perm),
  .rsp_exc     (rsp_exc),
  .rsp_err_code(rsp_err_code),
  .far_we      (far_we),
  .far_val     (far_val),
  .dsisr_we    (dsisr_we),
  .dsisr_val   (dsisr_val)
);

// File: tb/tb_xlat_fault_classifier.sv
module tb_xlat_fault_classifier;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_ea = '0;
  logic [1:0]  req_acc = '0;
  logic        instr_reloc_on = 1'b1;
  logic        data_reloc_on = 1'b1;
  logic        seg_hit = 1'b1;
  logic        seg_no_exec = 1'b0;
  logic        pte_hit = 1'b1;
  logic [2:0]  pte_perm = 3'b111;
  logic        pte_changed = 1'b1;
  logic [51:0] pte_rpn = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [63:0] rsp_raddr;
  logic [2:0]  rsp_perm;
  logic [2:0]  rsp_exc;
  logic [31:0] rsp_err_code;
  logic        far_we;
  logic [63:0] far_val;
  logic        dsisr_we;
  logic [31:0] dsisr_val;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [63:0] EA  = 64'hF123_4567_89AB_CDEF;
  localparam logic [63:0] EA_REAL = 64'h0123_4567_89AB_CDEF;
  localparam logic [51:0] RPN = 52'hA_BCDE_F012_3456;
  localparam logic [63:0] RA  = 64'hABCD_EF01_2345_6DEF;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_fault_classifier dut (.*);

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] acc, input logic ir, input logic dr,
                       input logic sh, input logic sn, input logic ph,
                       input logic [2:0] pp, input logic ch);
    req_acc = acc; instr_reloc_on = ir; data_reloc_on = dr; seg_hit = sh;
    seg_no_exec = sn; pte_hit = ph; pte_perm = pp; pte_changed = ch;
    req_ea = EA; pte_rpn = RPN;
  endtask

  // drives the prepared request, samples at the negedge after acceptance
  task automatic fire;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic f, input logic [63:0] ra,
                            input logic [2:0] pm, input logic [2:0] ex, input logic [31:0] er,
                            input logic fw, input logic [63:0] fv, input logic dw,
                            input logic [31:0] dv);
    chk(tag, {rsp_valid, rsp_fault, rsp_raddr, rsp_perm, rsp_exc, rsp_err_code,
              far_we, far_val, dsisr_we, dsisr_val},
             {1'b1, f, ra, pm, ex, er, fw, fv, dw, dv});
  endtask

  task automatic run_case(input string tag, input logic [1:0] acc, input logic ir,
                          input logic dr, input logic sh, input logic sn, input logic ph,
                          input logic [2:0] pp, input logic ch, input logic f,
                          input logic [63:0] ra, input logic [2:0] pm, input logic [2:0] ex,
                          input logic [31:0] er, input logic fw, input logic dw,
                          input logic [31:0] dv);
    setup(acc, ir, dr, sh, sn, ph, pp, ch);
    fire();
    expect_rsp(tag, f, ra, pm, ex, er, fw, fw ? EA : 64'h0, dw, dv);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 reset idle", {rsp_valid, req_ready}, {1'b0, 1'b1});
  endtask

  task automatic t_bypass;
    run_case("R1 fetch real mode", 2'd2, 0, 1, 0, 1, 0, 3'b000, 0,
             0, EA_REAL, 3'b111, 3'd0, 32'h0, 0, 0, 32'h0);
    run_case("R1 store real mode", 2'd1, 1, 0, 0, 0, 0, 3'b000, 0,
             0, EA_REAL, 3'b111, 3'd0, 32'h0, 0, 0, 32'h0);
    run_case("R1 fetch ignores data side", 2'd2, 1, 0, 0, 0, 1, 3'b111, 1,
             1, 64'h0, 3'b000, 3'd1, 32'h0, 0, 0, 32'h0);
  endtask

  task automatic t_segmiss;
    run_case("R3 fetch segment miss", 2'd2, 1, 1, 0, 0, 1, 3'b111, 1,
             1, 64'h0, 3'b000, 3'd1, 32'h0, 0, 0, 32'h0);
    run_case("R3 load segment miss", 2'd0, 1, 1, 0, 0, 1, 3'b111, 1,
             1, 64'h0, 3'b000, 3'd2, 32'h0, 1, 0, 32'h0);
  endtask

  task automatic t_noexec;
    run_case("R4 fetch no-exec", 2'd2, 1, 1, 1, 1, 1, 3'b111, 1,
             1, 64'h0, 3'b000, 3'd3, 32'h1000_0000, 0, 0, 32'h0);
    run_case("R4 load ignores no-exec", 2'd0, 1, 1, 1, 1, 1, 3'b011, 1,
             0, RA, 3'b011, 3'd0, 32'h0, 0, 0, 32'h0);
  endtask

  task automatic t_ptemiss;
    run_case("R5 fetch no entry", 2'd2, 1, 1, 1, 0, 0, 3'b111, 1,
             1, 64'h0, 3'b000, 3'd3, 32'h4000_0000, 0, 0, 32'h0);
    run_case("R5 load no entry", 2'd0, 1, 1, 1, 0, 0, 3'b111, 1,
             1, 64'h0, 3'b000, 3'd4, 32'h0, 1, 1, 32'h4000_0000);
    run_case("R5 store no entry", 2'd1, 1, 1, 1, 0, 0, 3'b111, 1,
             1, 64'h0, 3'b000, 3'd4, 32'h0, 1, 1, 32'h4200_0000);
  endtask

  task automatic t_perm;
    run_case("R6 fetch denied", 2'd2, 1, 1, 1, 0, 1, 3'b011, 1,
             1, 64'h0, 3'b000, 3'd3, 32'h0800_0000, 0, 0, 32'h0);
    run_case("R6 load denied", 2'd0, 1, 1, 1, 0, 1, 3'b110, 1,
             1, 64'h0, 3'b000, 3'd4, 32'h0, 1, 1, 32'h0800_0000);
    run_case("R6 store denied", 2'd1, 1, 1, 1, 0, 1, 3'b101, 1,
             1, 64'h0, 3'b000, 3'd4, 32'h0, 1, 1, 32'h0A00_0000);
  endtask

  task automatic t_need;
    run_case("R7 code 3 acts as load ok", 2'd3, 1, 1, 1, 0, 1, 3'b001, 1,
             0, RA, 3'b001, 3'd0, 32'h0, 0, 0, 32'h0);
    run_case("R7 code 3 load denied", 2'd3, 1, 1, 1, 0, 1, 3'b110, 1,
             1, 64'h0, 3'b000, 3'd4, 32'h0, 1, 1, 32'h0800_0000);
    run_case("R7 fetch needs exec only", 2'd2, 1, 1, 1, 0, 1, 3'b100, 1,
             0, RA, 3'b100, 3'd0, 32'h0, 0, 0, 32'h0);
  endtask

  task automatic t_changed;
    run_case("R8 load unchanged drops write", 2'd0, 1, 1, 1, 0, 1, 3'b111, 0,
             0, RA, 3'b101, 3'd0, 32'h0, 0, 0, 32'h0);
    run_case("R8 store unchanged keeps write", 2'd1, 1, 1, 1, 0, 1, 3'b111, 0,
             0, RA, 3'b111, 3'd0, 32'h0, 0, 0, 32'h0);
    run_case("R8 load changed keeps write", 2'd0, 1, 1, 1, 0, 1, 3'b111, 1,
             0, RA, 3'b111, 3'd0, 32'h0, 0, 0, 32'h0);
  endtask

  task automatic t_addr;
    // R9 and R11: translated success address, no register writes
    run_case("R9 R11 translated address", 2'd1, 1, 1, 1, 0, 1, 3'b010, 1,
             0, RA, 3'b010, 3'd0, 32'h0, 0, 0, 32'h0);
  endtask

  task automatic t_prio;
    run_case("R2 seg miss beats no-exec", 2'd2, 1, 1, 0, 1, 0, 3'b000, 1,
             1, 64'h0, 3'b000, 3'd1, 32'h0, 0, 0, 32'h0);
    run_case("R2 no-exec beats no entry", 2'd2, 1, 1, 1, 1, 0, 3'b000, 1,
             1, 64'h0, 3'b000, 3'd3, 32'h1000_0000, 0, 0, 32'h0);
    run_case("R2 no entry beats denied", 2'd1, 1, 1, 1, 0, 0, 3'b000, 1,
             1, 64'h0, 3'b000, 3'd4, 32'h0, 1, 1, 32'h4200_0000);
    run_case("R2 bypass beats all", 2'd0, 1, 0, 0, 1, 0, 3'b000, 0,
             0, EA_REAL, 3'b111, 3'd0, 32'h0, 0, 0, 32'h0);
  endtask

  task automatic t_stall;
    rsp_ready = 1'b0;
    setup(2'd0, 1, 1, 0, 0, 1, 3'b111, 1);
    fire();
    expect_rsp("R10 first held response", 1, 64'h0, 3'b000, 3'd2, 32'h0, 1, EA, 0, 32'h0);
    chk("R10 ready low under stall", {63'h0, req_ready}, 64'h0);
    setup(2'd2, 1, 1, 1, 0, 1, 3'b100, 1);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expect_rsp("R10 payload stable", 1, 64'h0, 3'b000, 3'd2, 32'h0, 1, EA, 0, 32'h0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R10 second after drain", 0, RA, 3'b100, 3'd0, 32'h0, 0, 64'h0, 0, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 empty after consume", {rsp_valid, req_ready}, {1'b0, 1'b1});
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_segmiss();
    t_noexec();
    t_ptemiss();
    t_perm();
    t_need();
    t_changed();
    t_addr();
    t_prio();
    t_stall();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule